// File: doc/BRIEF.md
# Iterative AES Round Engine

This block encrypts or decrypts one 128-bit block at a time under a 128, 192 or 256-bit AES key. It loops over a single round datapath. Each round is cut into four single-cycle sub-steps: byte substitution, row rotation, column mixing and round-key XOR. Encryption and decryption share one column mixer, and the substitution layer holds both the forward and the inverse table.

Key expansion is not part of the block. It asks for each round key on a request pin, in the order the cipher consumes them, and takes the key word in the same cycle. A decrypt run starts with one extra alignment cycle. After that cycle its round-key XOR, which is the third step of an inverse round, falls on the same cycle slots as the fourth step of an encrypt round.

The control pins are plain level and pulse signals. The round-key port is a request-driven stream with no back-pressure: a key is taken on every cycle where `key_req` is high, and the supplier cannot stall the engine. A start is taken only while `busy` is low.

Top module: `aes_round_engine`

## Requirements
- R1: While reset is held, and after reset is released with no start, `busy`, `done` and `key_req` are 0 and `result` is all zero.
- R2: One block raises `key_req` exactly Nr+1 times. Nr is 10 for `key_len`=0, 12 for `key_len`=1, and 14 for `key_len`=2 or 3.
- R3: Count cycles from the clock edge that accepts a start, calling the cycle after that edge cycle 1. `done` is high in cycle 4*Nr+2 for encryption and in cycle 4*Nr+3 for decryption.
- R4: With `decrypt`=0, round keys supplied in order rk0..rkNr, and the standard AES example vectors, `result` equals the reference ciphertext for all three key lengths. Byte k of a block sits at bits [127-8k -: 8] and maps to row k mod 4, column k div 4.
- R5: With `decrypt`=1 and round keys supplied in order rkNr..rk0, `result` equals the reference plaintext for all three key lengths. Inverse column mixing is skipped in the final decrypt round, and forward mixing is skipped in the final encrypt round.
- R6: For any key and block, encrypting and then decrypting with the matching key order returns the original block.
- R7: A start that arrives while `busy` is high has no effect. The running block's result, latency and key requests do not change.
- R8: `done` is high for exactly one cycle. `result` holds its value from the `done` cycle until the next start is accepted.
- R9: `key_req` is high in cycle 1 for encryption, or in cycle 2 for decryption, and then in cycles 5, 9, ..., 4*Nr+1. It is high in no other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block; taken only while busy is low |
| decrypt | input | 1 | 0 encrypt, 1 decrypt; sampled with start |
| key_len | input | 2 | 0: 128-bit, 1: 192-bit, 2 or 3: 256-bit; sampled with start |
| din | input | 128 | Input block, byte 0 in bits 127:120; sampled with start |
| busy | output | 1 | High from the cycle after an accepted start through the done cycle |
| key_req | output | 1 | The engine consumes key_in in this cycle |
| key_in | input | 128 | Round key, valid whenever key_req is high |
| done | output | 1 | One-cycle pulse; result is final |
| result | output | 128 | Output block |

## Verification
The bench runs the published example vectors for every key length in both directions, then sweeps round trips over pseudo-random keys and blocks. These runs catch a row rotation in the wrong direction, a column-major load read as row-major, a column mix that is not skipped in the final round, or a wrong inverse table. The bench records the exact cycle of every key request and of `done`. An engine without the decrypt alignment cycle, with an off-by-one round count, or that treats key-length code 3 as something other than 256 bits shows up as a timing or count mismatch. A start pulsed in the middle of a block, with different data and mode, exposes an engine that restarts. Sampling `result` after `done` exposes one that drifts.

// File: rtl/aes_pkg.sv
package aes_pkg;
  localparam int BYTE_W  = 8;
  localparam int BLK_W   = 128;
  localparam int NBYTES  = BLK_W / BYTE_W;
  localparam int NCOLS   = 4;
  localparam int COL_W   = BLK_W / NCOLS;
  localparam int KLEN_W  = 2;
  localparam int RND_W   = 4;
  localparam int LAT_W   = RND_W + 3;

  typedef enum logic [2:0] {PH_IDLE, PH_ALIGN, PH_INIT, PH_ROUND, PH_DONE} phase_e;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 8'h00;
    logic [7:0] sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xt(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254 (maps 0 to 0)
  function automatic logic [7:0] ginv(input logic [7:0] x);
    logic [7:0] r = 8'h01;
    logic [7:0] b = x;
    logic [7:0] e = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gmul(r, b);
      b = gmul(b, b);
    end
    return r;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sb_fwd(input logic [7:0] x);
    logic [7:0] y = ginv(x);
    return y ^ rl(y, 1) ^ rl(y, 2) ^ rl(y, 3) ^ rl(y, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sb_inv(input logic [7:0] x);
    return ginv(rl(x, 1) ^ rl(x, 3) ^ rl(x, 6) ^ 8'h05);
  endfunction

  function automatic logic [RND_W-1:0] round_total(input logic [KLEN_W-1:0] kl);
    case (kl)
      2'd0:    return 4'd10;
      2'd1:    return 4'd12;
      default: return 4'd14;
    endcase
  endfunction
endpackage

// File: rtl/aes_sub_layer.sv
module aes_sub_layer
  import aes_pkg::*;
#(
  parameter int NB = NBYTES
) (
  input  logic [NB*BYTE_W-1:0] din,
  input  logic                 inv,
  output logic [NB*BYTE_W-1:0] dout
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [BYTE_W-1:0] b_in;
    assign b_in = din[g*BYTE_W +: BYTE_W];
    assign dout[g*BYTE_W +: BYTE_W] = inv ? sb_inv(b_in) : sb_fwd(b_in);
  end
endmodule

// File: rtl/aes_shift_layer.sv
module aes_shift_layer
  import aes_pkg::*;
(
  input  logic [BLK_W-1:0] din,
  input  logic             inv,
  output logic [BLK_W-1:0] dout
);
  always_comb begin
    dout = din;
    for (int c = 0; c < NCOLS; c++) begin
      for (int r = 0; r < 4; r++) begin
        int sc;
        sc = inv ? ((c - r + NCOLS) % NCOLS) : ((c + r) % NCOLS);
        dout[BLK_W-1-BYTE_W*(c*4+r) -: BYTE_W] = din[BLK_W-1-BYTE_W*(sc*4+r) -: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/aes_mix_col.sv
module aes_mix_col
  import aes_pkg::*;
(
  input  logic [COL_W-1:0] col,
  input  logic             inv,
  output logic [COL_W-1:0] mixed
);
  logic [7:0] a [4];
  logic [7:0] a2 [4];
  logic [7:0] a4 [4];
  logic [7:0] a8 [4];

  for (genvar i = 0; i < 4; i++) begin : g_pow
    assign a[i]  = col[COL_W-1-8*i -: 8];
    assign a2[i] = xt(a[i]);
    assign a4[i] = xt(a2[i]);
    assign a8[i] = xt(a4[i]);
  end

  // coefficient picked by distance d from output row; shared doubling chain
  function automatic logic [7:0] term(input logic [7:0] p1, input logic [7:0] p2,
                                      input logic [7:0] p4, input logic [7:0] p8,
                                      input int d, input logic iv);
    if (!iv) begin
      case (d)
        0:       return p2;
        1:       return p2 ^ p1;
        default: return p1;
      endcase
    end else begin
      case (d)
        0:       return p8 ^ p4 ^ p2;
        1:       return p8 ^ p2 ^ p1;
        2:       return p8 ^ p4 ^ p1;
        default: return p8 ^ p1;
      endcase
    end
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      logic [7:0] s;
      s = 8'h00;
      for (int j = 0; j < 4; j++) begin
        s = s ^ term(a[j], a2[j], a4[j], a8[j], (j - i + 4) % 4, inv);
      end
      mixed[COL_W-1-8*i -: 8] = s;
    end
  end
endmodule

// File: rtl/aes_mix_layer.sv
module aes_mix_layer
  import aes_pkg::*;
(
  input  logic [BLK_W-1:0] din,
  input  logic             inv,
  output logic [BLK_W-1:0] dout
);
  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    aes_mix_col u_col (
      .col  (din[BLK_W-1-COL_W*c -: COL_W]),
      .inv  (inv),
      .mixed(dout[BLK_W-1-COL_W*c -: COL_W])
    );
  end
endmodule

// File: rtl/aes_round_engine.sv
module aes_round_engine
  import aes_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              decrypt,
  input  logic [KLEN_W-1:0] key_len,
  input  logic [BLK_W-1:0]  din,
  output logic              busy,
  output logic              key_req,
  input  logic [BLK_W-1:0]  key_in,
  output logic              done,
  output logic [BLK_W-1:0]  result
);
  phase_e           phase_q;
  logic [1:0]       step_q;
  logic [RND_W-1:0] rnd_q, nr_q;
  logic             inv_q;
  logic [BLK_W-1:0] st_q, st_nx;
  logic [BLK_W-1:0] sub_o, shf_o, mix_o;
  logic             last_rnd, take;

  aes_sub_layer   u_sub (.din(st_q), .inv(inv_q), .dout(sub_o));
  aes_shift_layer u_shf (.din(st_q), .inv(inv_q), .dout(shf_o));
  aes_mix_layer   u_mix (.din(st_q), .inv(inv_q), .dout(mix_o));

  assign last_rnd = (rnd_q == nr_q);
  assign take     = (phase_q == PH_IDLE) && start;
  assign busy     = (phase_q != PH_IDLE);
  assign done     = (phase_q == PH_DONE);
  assign result   = st_q;
  // encrypt XORs the key in step 3, decrypt in step 2
  assign key_req  = (phase_q == PH_INIT) ||
                    ((phase_q == PH_ROUND) && (step_q == (inv_q ? 2'd2 : 2'd3)));

  always_comb begin
    st_nx = st_q;
    if (!inv_q) begin
      case (step_q)
        2'd0: st_nx = sub_o;
        2'd1: st_nx = shf_o;
        2'd2: st_nx = last_rnd ? st_q : mix_o;
        default: st_nx = st_q ^ key_in;
      endcase
    end else begin
      case (step_q)
        2'd0: st_nx = shf_o;
        2'd1: st_nx = sub_o;
        2'd2: st_nx = st_q ^ key_in;
        default: st_nx = last_rnd ? st_q : mix_o;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      rnd_q   <= '0;
      nr_q    <= '0;
      inv_q   <= 1'b0;
      st_q    <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          st_q    <= din;
          inv_q   <= decrypt;
          nr_q    <= round_total(key_len);
          phase_q <= decrypt ? PH_ALIGN : PH_INIT;
        end
        PH_ALIGN: phase_q <= PH_INIT;
        PH_INIT: begin
          st_q    <= st_q ^ key_in;
          step_q  <= '0;
          rnd_q   <= 4'd1;
          phase_q <= PH_ROUND;
        end
        PH_ROUND: begin
          st_q   <= st_nx;
          step_q <= step_q + 2'd1;
          if (step_q == 2'd3) begin
            if (last_rnd) phase_q <= PH_DONE;
            else          rnd_q   <= rnd_q + 4'd1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // cycle and key-request counters observed by the properties below
  logic [LAT_W-1:0] lat_q;
  logic [RND_W-1:0] kcnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q  <= '0;
      kcnt_q <= '0;
    end else if (take) begin
      lat_q  <= 7'd1;
      kcnt_q <= '0;
    end else if (busy) begin
      lat_q <= lat_q + 7'd1;
      if (key_req) kcnt_q <= kcnt_q + 4'd1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done || (!busy && !start)) |=> $stable(result));  // R8
  AST_KEY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (kcnt_q == nr_q + 4'd1));  // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == ({1'b0, nr_q, 2'b00} + 7'd2 + {6'b0, inv_q})));  // R3
  AST_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    key_req |-> (busy && !done));  // R9
  AST_START_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);  // R7
endmodule

// File: tb/aes_round_engine_tb_top.sv
`timescale 1ns/1ps
module aes_round_engine_tb_top;
  logic         clk = 1'b0;
  logic         rst_n, start, decrypt;
  logic [1:0]   key_len;
  logic [127:0] din, key_in;
  logic         busy, key_req, done;
  logic [127:0] result;

  always #2 clk = ~clk;

  aes_round_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt), .key_len(key_len),
    .din(din), .busy(busy), .key_req(key_req), .key_in(key_in), .done(done), .result(result)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0]   sbox [256];
  logic [127:0] rk [15];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mul3(input logic [7:0] a);
    return a ^ ({a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00));
  endfunction

  function automatic logic [7:0] rot8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // table via exp/log of generator 3
  task automatic build_sbox();
    logic [7:0] ex [256];
    int         lg [256];
    ex[0] = 8'h01;
    for (int i = 1; i < 256; i++) ex[i] = mul3(ex[i-1]);
    for (int i = 0; i < 255; i++) lg[ex[i]] = i;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] y;
      y = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
      sbox[x] = y ^ rot8(y, 1) ^ rot8(y, 2) ^ rot8(y, 3) ^ rot8(y, 4) ^ 8'h63;
    end
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sbox[w[31:24]], sbox[w[23:16]], sbox[w[15:8]], sbox[w[7:0]]};
  endfunction

  task automatic expand(input logic [255:0] key, input int kl, output int nr);
    logic [31:0] w [60];
    logic [31:0] t;
    logic [7:0]  rc;
    int nk;
    nk = (kl == 0) ? 4 : (kl == 1) ? 6 : 8;
    nr = nk + 6;
    rc = 8'h01;
    for (int i = 0; i < nk; i++) w[i] = key[255-32*i -: 32];
    for (int i = nk; i < 4*(nr+1); i++) begin
      t = w[i-1];
      if (i % nk == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
      end else if (nk > 6 && i % nk == 4) begin
        t = subw(t);
      end
      w[i] = w[i-nk] ^ t;
    end
    for (int r = 0; r <= nr; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  // runs one block; keys taken from rk[] in the direction's order
  task automatic run_block(input bit dec, input logic [1:0] kl, input logic [127:0] blk,
                           input int nr, input int poke_at,
                           output logic [127:0] res, output int done_c,
                           output int nreq, output bit timing_ok);
    int idx;
    bit exp_req;
    idx = 0; nreq = 0; done_c = -1; timing_ok = 1; res = '0;
    @(negedge clk);
    start = 1'b1; decrypt = dec; key_len = kl; din = blk;
    for (int c = 1; c < 120; c++) begin
      @(negedge clk);
      if (c == poke_at) begin
        start = 1'b1; decrypt = ~dec; key_len = 2'd0; din = ~blk;
      end else begin
        start = 1'b0;
      end
      exp_req = (c == (dec ? 2 : 1)) || (c >= 5 && c <= 4*nr+1 && (c - 1) % 4 == 0);
      if (key_req != exp_req) timing_ok = 0;
      if (key_req) begin
        key_in = dec ? rk[nr - idx] : rk[idx];
        idx++;
        nreq++;
      end
      if (done) begin
        done_c = c;
        res = result;
        break;
      end
    end
    start = 1'b0;
    if (done_c < 0) chk(0, "run did not finish", '0, '0);
  endtask

  localparam logic [127:0] PT = 128'h00112233445566778899aabbccddeeff;
  localparam logic [255:0] FK = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;

  function automatic logic [127:0] ref_ct(input int kl);
    case (kl)
      0:       return 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
      1:       return 128'hdda97ca4864cdfe06eaf70a0ec0d7191;
      default: return 128'h8ea2b7ca516745bfeafc49904b496089;
    endcase
  endfunction

  initial begin
    #800000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] res, res2, ct, blk;
    logic [255:0] k;
    int nr, dc, nq;
    bit tok;
    build_sbox();
    rst_n = 1'b0; start = 1'b0; decrypt = 1'b0; key_len = 2'd0; din = '0; key_in = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !key_req, "R1 flags in reset", {busy, done, key_req}, '0);
    chk(result == '0, "R1 result in reset", result, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !key_req && result == '0, "R1 idle after reset", result, '0);

    for (int kl = 0; kl < 3; kl++) begin
      expand(FK, kl, nr);
      run_block(1'b0, kl[1:0], PT, nr, 0, res, dc, nq, tok);
      chk(res == ref_ct(kl), "R4 encrypt vector", res, ref_ct(kl));
      chk(dc == 4*nr+2, "R3 encrypt latency", dc, 4*nr+2);
      chk(nq == nr+1, "R2 key request count", nq, nr+1);
      chk(tok, "R9 encrypt key request cycles", tok, 1);
      run_block(1'b1, kl[1:0], ref_ct(kl), nr, 0, res, dc, nq, tok);
      chk(res == PT, "R5 decrypt vector", res, PT);
      chk(dc == 4*nr+3, "R3 decrypt latency", dc, 4*nr+3);
      chk(nq == nr+1, "R2 decrypt key request count", nq, nr+1);
      chk(tok, "R9 decrypt key request cycles", tok, 1);
    end

    // R2: key_len code 3 acts as 256-bit
    expand(FK, 2, nr);
    run_block(1'b0, 2'd3, PT, nr, 0, res, dc, nq, tok);
    chk(res == ref_ct(2), "R2 code 3 result", res, ref_ct(2));
    chk(nq == 15 && dc == 58, "R2 code 3 timing", dc, 58);

    // R8: done single cycle, result held
    expand(FK, 0, nr);
    run_block(1'b0, 2'd0, PT, nr, 0, res, dc, nq, tok);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!done, "R8 done one cycle", done, 0);
      chk(result == ref_ct(0), "R8 result held", result, ref_ct(0));
    end

    // R7: start mid-block ignored
    run_block(1'b0, 2'd0, PT, nr, 10, res, dc, nq, tok);
    chk(res == ref_ct(0), "R7 busy start result", res, ref_ct(0));
    chk(dc == 42 && nq == 11 && tok, "R7 busy start timing", dc, 42);
    @(negedge clk);
    chk(!busy, "R7 no late restart", busy, 0);

    // R6: round-trip sweep
    for (int kl = 0; kl < 3; kl++) begin
      for (int n = 0; n < 6; n++) begin
        k   = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        blk = {$urandom, $urandom, $urandom, $urandom};
        expand(k, kl, nr);
        run_block(1'b0, kl[1:0], blk, nr, 0, ct, dc, nq, tok);
        run_block(1'b1, kl[1:0], ct, nr, 0, res2, dc, nq, tok);
        chk(res2 == blk && ct != blk, "R6 round trip", res2, blk);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule